// File: doc/BRIEF.md
# BCD Clock-Calendar with Digital Trim

This block keeps time of day and the calendar as packed BCD bytes. It holds seconds, minutes, hours, date, month, a two-digit year, a century byte and a day-of-week counter. A prescaler counts a fast clock enable and turns it into a one-second step. A signed digital trim shortens or lengthens some seconds over an averaging window, so the mean rate moves by a chosen amount in parts per million.

The host never touches the live counters directly. A read starts with `snap_load`, which freezes every byte into a snapshot. `rd_addr` then selects a byte of that frozen copy while the counters keep running. A write starts with `stage_load`, which copies the live time into a staging buffer. Each `wr_en` strobe replaces one buffer byte. `commit`, which marks a valid end of the transaction, moves the whole buffer into the counters. `abort` throws the buffer away.

After reset the block treats itself as having lost all power. The counters stay halted and the fail flag is raised until the first committed write that contains at least one byte.

Top module: `bcd_rtc`

## Requirements
- R1: Byte 0 (seconds) and byte 1 (minutes) count 00 to 59 in packed BCD. Seconds carry into minutes, and minutes into hours, when they pass 59.
- R2: When bit 7 of byte 2 (hour) is 1, hours count 00 to 23. The step after 23 gives 00 with bit 7 still set and advances the date.
- R3: When bit 7 of byte 2 is 0, bits 4:0 hold the hour 01 to 12 and bit 5 is the PM flag (1 means PM). The flag toggles on the step from 11 to 12. The step after 12 gives 01. The step from 11 PM to 12 AM advances the date.
- R4: Date (byte 3) wraps from the end of the month to 01 and advances month (byte 4). February ends on 29 when the BCD year (byte 5) is divisible by 4, including year 00, and on 28 otherwise. April, June, September and November end on 30, and every other month ends on 31.
- R5: Day of week (byte 6) steps 0 through 6 and then back to 0, once per date advance. Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00 and advances the century (byte 7). Reset values for bytes 0 to 7 are 00,00,12,01,01,00,00,20.
- R6: A `snap_load` pulse copies all eight live bytes into a snapshot. `rd_data` shows snapshot byte `rd_addr` and does not follow the running counters until the next `snap_load`.
- R7: A `stage_load` pulse copies the live bytes into the staging buffer. A `wr_en` pulse replaces only byte `wr_addr`. A `commit` after at least one byte write loads all eight buffer bytes into the counters. An `abort`, or a `commit` with no byte write, leaves the counters unchanged.
- R8: After a loading commit the second prescaler restarts from zero. The next `sec_tick` pulse, together with the next time step, comes after exactly one full second of `tick_en` counts.
- R9: From reset the counters do not advance and `clock_fail` is 1. The first loading commit clears `clock_fail` and starts the counters.
- R10: `trim` bit 2 is the sign (0 = faster, 1 = slower). The magnitude is bit 1 × 1 + bit 0 × 2 in 10 ppm units, and codes 000 and 100 give no correction. Each second adds magnitude×STEP to an accumulator modulo WINDOW. A wrap shortens the next second by one count when the sign is 0, or lengthens it by one count when the sign is 1.
- R11: A byte written above its field maximum is stored as written and goes to the field minimum on its next step, without carrying into the next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (total power loss) |
| tick_en | input | 1 | Prescaler count enable (nominally 32768 per second) |
| trim | input | 3 | Signed digital rate trim code |
| snap_load | input | 1 | Freeze live time into the read snapshot |
| rd_addr | input | 3 | Snapshot byte select |
| rd_data | output | 8 | Selected snapshot byte |
| stage_load | input | 1 | Copy live time into the staging buffer |
| wr_en | input | 1 | Write one staging byte |
| wr_addr | input | 3 | Staging byte select |
| wr_data | input | 8 | Staging byte value |
| commit | input | 1 | Valid end of write: load the buffer into the counters |
| abort | input | 1 | Invalid end of write: discard the buffer |
| sec_tick | output | 1 | One-cycle pulse on each time step |
| clock_fail | output | 1 | Set from reset until the first loading commit |

## Verification
The states that are hardest to reach are the long carry chains: 11 PM to 12 AM, the end of December in year 99, and the end of February in leap and non-leap years. The stimulus reaches each of them in a few cycles by staging a time one or two seconds before the edge and committing it. A small prescaler divisor keeps every second short. The trim accumulator is observed through whole windows of seconds. Over a window the number of shortened or lengthened seconds is fixed whatever the accumulator held at the start, so the measured cycle count can be predicted exactly.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int DIV    = 32768,
  parameter int WINDOW = 3125,
  parameter int STEP   = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [2:0] trim,
  input  logic       snap_load,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       stage_load,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       commit,
  input  logic       abort,
  output logic       sec_tick,
  output logic       clock_fail
);
  localparam int PCW = $clog2(DIV + 2);
  localparam int AW  = $clog2(WINDOW + 3 * STEP + 1);
  localparam logic [PCW-1:0] LEN_N = PCW'(DIV);
  localparam logic [PCW-1:0] LEN_S = PCW'(DIV - 1);
  localparam logic [PCW-1:0] LEN_L = PCW'(DIV + 1);

  logic [7:0] live [8];
  logic [7:0] stage [8];
  logic [7:0] snap [8];
  logic [7:0] nx [8];
  logic [PCW-1:0] pc;
  logic [AW-1:0]  acc;
  logic adj, halted, dirty, fail_q, tick_q;

  function automatic logic [7:0] inc(input logic [7:0] b);
    return (b[3:0] >= 4'd9) ? {b[7:4] + 4'd1, 4'd0} : b + 8'd1;
  endfunction

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      2: return 8'h12;
      3, 4: return 8'h01;
      7: return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  wire load = commit & dirty;
  wire [1:0] mag = {trim[0], trim[1]};
  wire [PCW-1:0] len = adj ? (trim[2] ? LEN_L : LEN_S) : LEN_N;
  wire sec_edge = !halted && tick_en && (pc == len - PCW'(1));
  wire [AW-1:0] acc_sum = acc + AW'(mag) * AW'(STEP);
  wire leap = ((live[5][1:0] + {live[5][4], 1'b0}) == 2'b00);

  assign rd_data    = snap[rd_addr];
  assign sec_tick   = tick_q;
  assign clock_fail = fail_q;

  always_comb begin
    logic c_s, c_m, c_h, c_d, c_mo, c_y;
    logic [7:0] hi, mlen;
    nx = live;
    c_s = 1'b0; c_m = 1'b0; c_h = 1'b0; c_d = 1'b0; c_mo = 1'b0; c_y = 1'b0;
    hi = 8'h00;
    case (live[4])
      8'h02: mlen = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
      default: mlen = 8'h31;
    endcase
    c_s = (live[0] == 8'h59);
    nx[0] = (live[0] >= 8'h59) ? 8'h00 : inc(live[0]);
    if (c_s) begin
      c_m = (live[1] == 8'h59);
      nx[1] = (live[1] >= 8'h59) ? 8'h00 : inc(live[1]);
    end
    if (c_m) begin
      if (live[2][7]) begin
        hi = inc({2'b00, live[2][5:0]});
        c_h = (live[2][5:0] == 6'h23);
        nx[2] = (live[2][5:0] >= 6'h23) ? 8'h80 : {2'b10, hi[5:0]};
      end else begin
        hi = inc({3'b000, live[2][4:0]});
        if (live[2][4:0] == 5'h11) begin
          c_h = live[2][5];
          nx[2] = {2'b00, ~live[2][5], 5'h12};
        end else if (live[2][4:0] >= 5'h12 || live[2][4:0] == 5'h00)
          nx[2] = {2'b00, live[2][5], 5'h01};
        else
          nx[2] = {2'b00, live[2][5], hi[4:0]};
      end
    end
    if (c_h) begin
      c_d = (live[3] == mlen);
      nx[3] = (live[3] >= mlen || live[3] == 8'h00) ? 8'h01 : inc(live[3]);
      nx[6] = (live[6] >= 8'd6) ? 8'd0 : live[6] + 8'd1;
    end
    if (c_d) begin
      c_mo = (live[4] == 8'h12);
      nx[4] = (live[4] >= 8'h12 || live[4] == 8'h00) ? 8'h01 : inc(live[4]);
    end
    if (c_mo) begin
      c_y = (live[5] == 8'h99);
      nx[5] = (live[5] >= 8'h99) ? 8'h00 : inc(live[5]);
    end
    if (c_y) nx[7] = (live[7] >= 8'h99) ? 8'h00 : inc(live[7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        live[i]  <= rst_val(i);
        stage[i] <= rst_val(i);
        snap[i]  <= rst_val(i);
      end
      pc <= '0; acc <= '0; adj <= 1'b0;
      halted <= 1'b1; dirty <= 1'b0; fail_q <= 1'b1; tick_q <= 1'b0;
    end else begin
      tick_q <= sec_edge && !load;
      if (snap_load) snap <= live;
      if (stage_load) begin
        stage <= live;
        dirty <= 1'b0;
      end else if (wr_en) begin
        stage[wr_addr] <= wr_data;
        dirty <= 1'b1;
      end
      if (load || abort) dirty <= 1'b0;
      if (load) begin
        live <= stage;
        pc <= '0;
        halted <= 1'b0;
        fail_q <= 1'b0;
      end else if (!halted && tick_en) begin
        if (sec_edge) begin
          pc <= '0;
          live <= nx;
          adj <= (acc_sum >= AW'(WINDOW));
          acc <= (acc_sum >= AW'(WINDOW)) ? acc_sum - AW'(WINDOW) : acc_sum;
        end else begin
          pc <= pc + PCW'(1);
        end
      end
    end
  end

  p_sec_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (live[0] <= 8'h59 && !load) |=> live[0] <= 8'h59);
  p_dow_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live[6] <= 8'd6 && !load) |=> live[6] <= 8'd6);
  p_snap_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_load |=> (!$stable(rd_addr) || $stable(rd_data)));
  p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> !$past(sec_tick));
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !load) |=> ($stable(live[0]) && !sec_tick));
  p_fail_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clock_fail) |-> $past(load));
endmodule

// File: tb/bcd_rtc_bench.sv
module bcd_rtc_bench;
  localparam int DIV = 8, WINDOW = 7, STEP = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, tick_en = 1'b1, snap_load = 1'b0, stage_load = 1'b0;
  logic wr_en = 1'b0, commit = 1'b0, abort = 1'b0;
  logic [2:0] trim = 3'b100, rd_addr = 3'd0, wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  wire  [7:0] rd_data;
  wire        sec_tick, clock_fail;

  bcd_rtc #(.DIV(DIV), .WINDOW(WINDOW), .STEP(STEP)) u_bcd_rtc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .trim(trim),
    .snap_load(snap_load), .rd_addr(rd_addr), .rd_data(rd_data),
    .stage_load(stage_load), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .abort(abort), .sec_tick(sec_tick), .clock_fail(clock_fail));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [7:0] got [8];

  // behavioural reference
  logic [7:0] m_live [8], m_stage [8], m_snap [8];
  int m_pc, m_acc;
  bit m_adj, m_halt, m_dirty, m_fail, m_tick;

  function automatic int b2i(input logic [7:0] b); return b[7:4] * 10 + b[3:0]; endfunction
  function automatic logic [7:0] i2b(input int v); return 8'((v / 10) * 16 + v % 10); endfunction

  function automatic void m_reset();
    logic [7:0] r [8];
    r = '{8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 8'h00, 8'h20};
    m_live = r; m_stage = r; m_snap = r;
    m_pc = 0; m_acc = 0; m_adj = 0; m_halt = 1; m_dirty = 0; m_fail = 1; m_tick = 0;
  endfunction

  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic void m_adv();
    int v, h; bit c, pm;
    v = b2i(m_live[0]); c = (v == 59); m_live[0] = (v >= 59) ? 8'h00 : i2b(v + 1);
    if (!c) return;
    v = b2i(m_live[1]); c = (v == 59); m_live[1] = (v >= 59) ? 8'h00 : i2b(v + 1);
    if (!c) return;
    if (m_live[2][7]) begin
      h = b2i({2'b00, m_live[2][5:0]}); c = (h == 23);
      m_live[2] = 8'h80 | ((h >= 23) ? 8'h00 : i2b(h + 1));
    end else begin
      h = b2i({3'b000, m_live[2][4:0]}); pm = m_live[2][5]; c = 0;
      if (h == 11) begin c = pm; pm = !pm; h = 12; end
      else if (h >= 12 || h == 0) h = 1;
      else h = h + 1;
      m_live[2] = (pm ? 8'h20 : 8'h00) | i2b(h);
    end
    if (!c) return;
    m_live[6] = (m_live[6] >= 6) ? 8'd0 : m_live[6] + 8'd1;
    v = b2i(m_live[3]); h = days_in(b2i(m_live[4]), b2i(m_live[5]));
    c = (v == h); m_live[3] = (v >= h || v == 0) ? 8'h01 : i2b(v + 1);
    if (!c) return;
    v = b2i(m_live[4]); c = (v == 12); m_live[4] = (v >= 12 || v == 0) ? 8'h01 : i2b(v + 1);
    if (!c) return;
    v = b2i(m_live[5]); c = (v == 99); m_live[5] = (v >= 99) ? 8'h00 : i2b(v + 1);
    if (!c) return;
    v = b2i(m_live[7]); m_live[7] = (v >= 99) ? 8'h00 : i2b(v + 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      logic [7:0] old_stage [8];
      bit ld;
      int len, mg;
      old_stage = m_stage;
      ld = commit && m_dirty;
      m_tick = 0;
      if (snap_load) m_snap = m_live;
      if (stage_load) begin m_stage = m_live; m_dirty = 0; end
      else if (wr_en) begin m_stage[wr_addr] = wr_data; m_dirty = 1; end
      if (ld || abort) m_dirty = 0;
      if (ld) begin
        m_live = old_stage; m_pc = 0; m_halt = 0; m_fail = 0;
      end else if (!m_halt && tick_en) begin
        len = DIV + (m_adj ? (trim[2] ? 1 : -1) : 0);
        if (m_pc == len - 1) begin
          m_pc = 0; m_tick = 1; m_adv();
          mg = (trim[1] ? 1 : 0) + (trim[0] ? 2 : 0);
          m_acc = m_acc + mg * STEP;
          m_adj = (m_acc >= WINDOW);
          if (m_adj) m_acc = m_acc - WINDOW;
        end else m_pc++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(sec_tick === m_tick, "R8/R10 sec_tick timing", sec_tick, m_tick);
    chk(clock_fail === m_fail, "R9 clock_fail", clock_fail, m_fail);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic stage_start(); @(negedge clk) stage_load = 1; @(negedge clk) stage_load = 0; endtask
  task automatic wbyte(input int a, input logic [7:0] d);
    @(negedge clk) begin wr_en = 1; wr_addr = 3'(a); wr_data = d; end
    @(negedge clk) wr_en = 0;
  endtask
  task automatic do_commit(); @(negedge clk) commit = 1; @(negedge clk) commit = 0; endtask
  task automatic do_abort(); @(negedge clk) abort = 1; @(negedge clk) abort = 0; endtask

  task automatic set_all(input logic [7:0] s, mi, h, d, mo, y, w, c);
    stage_start();
    wbyte(0, s); wbyte(1, mi); wbyte(2, h); wbyte(3, d);
    wbyte(4, mo); wbyte(5, y); wbyte(6, w); wbyte(7, c);
    do_commit();
  endtask

  task automatic read_all(input string req);
    @(negedge clk) snap_load = 1;
    @(negedge clk) snap_load = 0;
    for (int i = 0; i < 8; i++) begin
      rd_addr = 3'(i); #0.5;
      got[i] = rd_data;
      chk(got[i] === m_snap[i], req, got[i], m_snap[i]);
    end
  endtask

  task automatic expect_b(input int i, input logic [7:0] v, input string req);
    chk(got[i] === v, req, got[i], v);
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin @(negedge clk); if (sec_tick) k++; end
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state and halt
    read_all("R5 reset values");
    expect_b(2, 8'h12, "R5 reset hour"); expect_b(7, 8'h20, "R5 reset century");
    chk(clock_fail === 1'b1, "R9 fail after reset", clock_fail, 1);
    repeat (40) @(negedge clk);
    stage_start(); do_commit();
    repeat (20) @(negedge clk);
    read_all("R9 halted");
    expect_b(0, 8'h00, "R9 still halted after empty commit");
    chk(clock_fail === 1'b1, "R9 fail kept by empty commit", clock_fail, 1);
    // R7 single byte write, R8 first second length
    stage_start(); wbyte(0, 8'h58);
    @(negedge clk) commit = 1;
    @(negedge clk) commit = 0;
    cnt = 0;
    do begin cnt++; @(negedge clk); end while (!sec_tick && cnt < 100);
    chk(cnt == DIV, "R8 first second after commit", cnt, DIV);
    chk(clock_fail === 1'b0, "R9 fail cleared", clock_fail, 0);
    wait_ticks(1);
    read_all("R1 minute carry");
    expect_b(0, 8'h00, "R1 seconds wrap"); expect_b(1, 8'h01, "R1 minute carry");
    expect_b(2, 8'h12, "R7 untouched hour");
    // R7 abort and R6 frozen snapshot
    stage_start(); wbyte(1, 8'h33); do_abort();
    wait_ticks(1);
    read_all("R7 abort");
    expect_b(1, 8'h01, "R7 abort keeps minute");
    wait_ticks(3);
    rd_addr = 3'd0; #0.5;
    chk(rd_data === got[0], "R6 snapshot frozen", rd_data, got[0]);
    // R1 gapped enables
    for (int i = 0; i < 300; i++) begin @(negedge clk) tick_en = (i % 3) != 0; end
    @(negedge clk) tick_en = 1;
    read_all("R1 gapped enables");
    // R2 and R5: end of century year
    set_all(8'h58, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h06, 8'h19);
    wait_ticks(2);
    read_all("R2 R5 rollover");
    expect_b(2, 8'h80, "R2 hour 23 to 00"); expect_b(3, 8'h01, "R4 date wrap");
    expect_b(4, 8'h01, "R5 month wrap"); expect_b(5, 8'h00, "R5 year wrap");
    expect_b(6, 8'h00, "R5 dow wrap"); expect_b(7, 8'h20, "R5 century step");
    // R3 12-hour mode
    set_all(8'h58, 8'h59, 8'h11, 8'h10, 8'h05, 8'h21, 8'h02, 8'h20);
    wait_ticks(2);
    read_all("R3 noon");
    expect_b(2, 8'h32, "R3 11AM to 12PM"); expect_b(3, 8'h10, "R3 no date step at noon");
    wait_ticks(1);
    set_all(8'h58, 8'h59, 8'h31, 8'h10, 8'h05, 8'h21, 8'h02, 8'h20);
    wait_ticks(2);
    read_all("R3 midnight");
    expect_b(2, 8'h12, "R3 11PM to 12AM"); expect_b(3, 8'h11, "R3 date step");
    expect_b(6, 8'h03, "R5 dow step");
    set_all(8'h58, 8'h59, 8'h12, 8'h10, 8'h05, 8'h21, 8'h02, 8'h20);
    wait_ticks(2);
    read_all("R3 12 to 1");
    expect_b(2, 8'h01, "R3 12AM to 1AM");
    // R4 month lengths
    set_all(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h01, 8'h20);
    wait_ticks(1); read_all("R4 leap");
    expect_b(3, 8'h29, "R4 Feb 29 in year 24");
    set_all(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h01, 8'h20);
    wait_ticks(1); read_all("R4 non-leap");
    expect_b(3, 8'h01, "R4 Feb 28 wrap"); expect_b(4, 8'h03, "R4 March");
    set_all(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h00, 8'h01, 8'h20);
    wait_ticks(1); read_all("R4 year 00");
    expect_b(3, 8'h29, "R4 Feb 29 in year 00");
    set_all(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h23, 8'h01, 8'h20);
    wait_ticks(1); read_all("R4 april");
    expect_b(3, 8'h01, "R4 Apr 30 wrap"); expect_b(4, 8'h05, "R4 May");
    // R11 out-of-range values
    set_all(8'h75, 8'h10, 8'h85, 8'h31, 8'h04, 8'h23, 8'h01, 8'h20);
    wait_ticks(1); read_all("R11 out of range");
    expect_b(0, 8'h00, "R11 seconds to minimum"); expect_b(1, 8'h10, "R11 no minute carry");
    set_all(8'h59, 8'h59, 8'hA3, 8'h31, 8'h04, 8'h23, 8'h01, 8'h20);
    wait_ticks(1); read_all("R11 date");
    expect_b(3, 8'h01, "R11 date to 01"); expect_b(4, 8'h04, "R11 no month carry");
    // R10 trim windows
    trim = 3'b011; wait_ticks(2);
    cnt = 0; wait_ticks(0);
    begin int k = 0; while (k < 7) begin @(negedge clk); cnt++; if (sec_tick) k++; end end
    chk(cnt == 7 * DIV - 6, "R10 +30 window", cnt, 7 * DIV - 6);
    trim = 3'b111; wait_ticks(2);
    cnt = 0;
    begin int k = 0; while (k < 7) begin @(negedge clk); cnt++; if (sec_tick) k++; end end
    chk(cnt == 7 * DIV + 6, "R10 -30 window", cnt, 7 * DIV + 6);
    trim = 3'b010; wait_ticks(2);
    cnt = 0;
    begin int k = 0; while (k < 7) begin @(negedge clk); cnt++; if (sec_tick) k++; end end
    chk(cnt == 7 * DIV - 2, "R10 +10 window", cnt, 7 * DIV - 2);
    trim = 3'b100; wait_ticks(2);
    cnt = 0;
    begin int k = 0; while (k < 7) begin @(negedge clk); cnt++; if (sec_tick) k++; end end
    chk(cnt == 7 * DIV, "R10 zero code", cnt, 7 * DIV);
    for (int t = 0; t < 8; t++) begin trim = 3'(t); wait_ticks(20); end
    read_all("R10 trim sweep");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule